// File: doc/BRIEF.md
# Radio-State GPIO Controller

A 32-bit general-purpose I/O block whose output levels follow the transmit/receive activity of a radio. Software loads four pattern registers, one per radio condition (quiet, receiving, transmitting, both). Each clock the live `tx_active`/`rx_active` pair picks one pattern and the block drives it onto the pins. A per-bit static mask lets any pin ignore the radio condition and hold the level kept in the quiet pattern. A direction register drives the pad output enables.

Configuration arrives on a plain write port: a strobe, a byte address, a half-select code and a data word. The port accepts a write on every cycle it is strobed, with no back-pressure. The port has no ready signal, so no write can be stalled or lost. A readback word reports every pin. An output pin returns the level being driven. An input pin returns its pad level after a two-flop synchronizer. A half-select lets one call update only the lower half (receive-side pins) or only the upper half (transmit-side pins) of a register.

Top module: `atrgpio_ctrl`

## Requirements
- R1: Register `i` sits at byte address `i*STRIDE` (default stride 4). The indices are: quiet pattern 0, receive pattern 1, transmit pattern 2, full-duplex pattern 3, direction 4, static mask 5. A strobed write updates the register at the clock edge that samples the strobe.
- R2: The pattern is chosen by `{tx_active, rx_active}`: 00 quiet, 01 receive, 10 transmit, 11 full-duplex. `pin_out` is registered and shows the choice one clock edge after the inputs change.
- R3: A pin whose static-mask bit is 1 drives the bit of the quiet pattern whatever the radio condition. A pin whose mask bit is 0 drives the chosen pattern.
- R4: `pin_oe` bit equals the direction register bit (1 = output, 0 = input).
- R5: `readback` equals `pin_out` on output pins. On input pins it equals `pin_in` delayed through two flops, so a pad change shows two edges later.
- R6: No register changes for a write whose address is not one of the six register addresses (including misaligned ones), or when `wr_en` is low.
- R7: `wr_unit` 00 or 11 writes the full word. 01 writes `wr_data[15:0]` into bits 15:0. 10 writes `wr_data[15:0]` into bits 31:16. The half not selected keeps its value.
- R8: Asynchronous active-low reset clears all registers, the synchronizer and `pin_out`. After reset every pin is an input and follows the radio condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Byte address of the register |
| wr_unit | input | 2 | Half-select code (see R7) |
| wr_data | input | 32 | Write data |
| tx_active | input | 1 | Radio transmitting |
| rx_active | input | 1 | Radio receiving |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Pad output levels |
| pin_oe | output | 32 | Pad output enables |
| readback | output | 32 | Per-pin readback |

## Verification
The embedded assertions check several properties on every cycle. An idle strobe or a miss on every register address leaves the bank unchanged. A half write preserves the other half. A full write stores the data. An all-static mask or the quiet condition makes `pin_out` equal to the quiet pattern one edge later. Output pins read back their driven level. The two-edge synchronizer latency, the pattern selection for each radio condition and mixed static/state masks need stimulus over time. The bench's reference model shows these, comparing every output on every clock.

// File: rtl/atrgpio_pkg.sv
package atrgpio_pkg;

  typedef enum logic [1:0] {
    ST_QUIET = 2'b00,
    ST_RX    = 2'b01,
    ST_TX    = 2'b10,
    ST_FDX   = 2'b11
  } radio_state_e;

  typedef enum logic [1:0] {
    UNIT_FULL_A = 2'b00,
    UNIT_LOW    = 2'b01,
    UNIT_HIGH   = 2'b10,
    UNIT_FULL_B = 2'b11
  } wr_unit_e;

  localparam int NUM_REGS   = 6;
  localparam int NUM_STATES = 4;
  localparam int IDX_QUIET  = 0;
  localparam int IDX_RX     = 1;
  localparam int IDX_TX     = 2;
  localparam int IDX_FDX    = 3;
  localparam int IDX_DIR    = 4;
  localparam int IDX_STATIC = 5;

endpackage

// File: rtl/atrgpio_regbank.sv
module atrgpio_regbank
  import atrgpio_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8,
  parameter int STRIDE = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [1:0]                       wr_unit,
  input  logic [WIDTH-1:0]                 wr_data,
  output logic [NUM_STATES-1:0][WIDTH-1:0] pattern_q,
  output logic [WIDTH-1:0]                 dir_q,
  output logic [WIDTH-1:0]                 static_q
);

  localparam int HALF = WIDTH / 2;

  logic [NUM_REGS-1:0][WIDTH-1:0] regs_q;
  logic [NUM_REGS-1:0]            hit;

  function automatic logic [WIDTH-1:0] merge_word(
    input logic [WIDTH-1:0] old_w,
    input logic [WIDTH-1:0] new_w,
    input logic [1:0]       unit
  );
    logic [WIDTH-1:0] res;
    case (wr_unit_e'(unit))
      UNIT_LOW:  res = {old_w[WIDTH-1:HALF], new_w[HALF-1:0]};
      UNIT_HIGH: res = {new_w[HALF-1:0], old_w[HALF-1:0]};
      default:   res = new_w;
    endcase
    return res;
  endfunction

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign hit[i] = wr_en && (wr_addr == ADDR_W'(i * STRIDE));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (hit[i]) begin
        regs_q[i] <= merge_word(regs_q[i], wr_data, wr_unit);
      end
    end

    // R1: a full-word write stores the data
    p_full_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && (wr_unit == 2'b00 || wr_unit == 2'b11)) |=> regs_q[i] == $past(wr_data));

    // R7: a low-half write keeps the upper half
    p_low_keeps_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && wr_unit == 2'b01) |=> regs_q[i][WIDTH-1:HALF] == $past(regs_q[i][WIDTH-1:HALF]));

    // R7: a high-half write keeps the lower half
    p_high_keeps_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && wr_unit == 2'b10) |=> regs_q[i][HALF-1:0] == $past(regs_q[i][HALF-1:0]));
  end

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_pat
    assign pattern_q[s] = regs_q[s];
  end

  assign dir_q    = regs_q[IDX_DIR];
  assign static_q = regs_q[IDX_STATIC];

  // R6: no strobe, no change
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));

  // R6: strobe on an unmapped address changes nothing
  p_unmapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit == '0) |=> $stable(regs_q));

  initial begin
    assert (WIDTH % 2 == 0) else $error("WIDTH must be even");
    assert (STRIDE > 0) else $error("STRIDE must be positive");
  end

endmodule

// File: rtl/atrgpio_pinmux.sv
module atrgpio_pinmux
  import atrgpio_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tx_active,
  input  logic                             rx_active,
  input  logic [NUM_STATES-1:0][WIDTH-1:0] pattern_q,
  input  logic [WIDTH-1:0]                 static_q,
  output logic [WIDTH-1:0]                 out_q
);

  radio_state_e     state;
  logic [WIDTH-1:0] chosen;
  logic [WIDTH-1:0] out_d;

  assign state = radio_state_e'({tx_active, rx_active});

  always_comb begin
    case (state)
      ST_RX:   chosen = pattern_q[IDX_RX];
      ST_TX:   chosen = pattern_q[IDX_TX];
      ST_FDX:  chosen = pattern_q[IDX_FDX];
      default: chosen = pattern_q[IDX_QUIET];
    endcase
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign out_d[b] = static_q[b] ? pattern_q[IDX_QUIET][b] : chosen[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  // R3: all pins static means the quiet pattern is driven
  p_all_static_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&static_q) |=> out_q == $past(pattern_q[IDX_QUIET]));

  // R2: quiet condition drives the quiet pattern regardless of mask
  p_quiet_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !rx_active) |=> out_q == $past(pattern_q[IDX_QUIET]));

endmodule

// File: rtl/atrgpio_sync.sv
module atrgpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/atrgpio_ctrl.sv
module atrgpio_ctrl
  import atrgpio_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_unit,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              tx_active,
  input  logic              rx_active,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  readback
);

  localparam int SYNC_STAGES = 2;

  logic [NUM_STATES-1:0][WIDTH-1:0] pattern_q;
  logic [WIDTH-1:0]                 dir_q;
  logic [WIDTH-1:0]                 static_q;
  logic [WIDTH-1:0]                 pin_sync;

  atrgpio_regbank #(
    .WIDTH  (WIDTH),
    .ADDR_W (ADDR_W),
    .STRIDE (STRIDE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_unit   (wr_unit),
    .wr_data   (wr_data),
    .pattern_q (pattern_q),
    .dir_q     (dir_q),
    .static_q  (static_q)
  );

  atrgpio_pinmux #(
    .WIDTH (WIDTH)
  ) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .rx_active (rx_active),
    .pattern_q (pattern_q),
    .static_q  (static_q),
    .out_q     (pin_out)
  );

  atrgpio_sync #(
    .WIDTH  (WIDTH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  assign pin_oe   = dir_q;
  assign readback = (dir_q & pin_out) | (~dir_q & pin_sync);

  // R5: with every pin an output, readback mirrors the driven level
  p_out_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe == '1) |-> readback == pin_out);

  // R4: the direction register changes only on a strobed write
  p_oe_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_oe));

endmodule

// File: tb/atrgpio_ctrl_test.sv
module atrgpio_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [1:0]  wr_unit = '0;
  logic [31:0] wr_data = '0;
  logic        tx_active = 1'b0;
  logic        rx_active = 1'b0;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, readback;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  atrgpio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_unit(wr_unit), .wr_data(wr_data), .tx_active(tx_active),
    .rx_active(rx_active), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .readback(readback)
  );

  // Behavioural reference model
  logic [31:0] m_reg [6];
  logic [31:0] m_s1, m_s2, m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m_reg[i] = '0;
      m_s1 = '0; m_s2 = '0; m_out = '0;
    end else begin
      logic [31:0] pick, nxt;
      int st;
      st = tx_active * 2 + rx_active;
      pick = m_reg[st];
      for (int b = 0; b < 32; b++)
        nxt[b] = m_reg[5][b] ? m_reg[0][b] : pick[b];
      if (wr_en && (wr_addr % 4 == 0) && (wr_addr / 4 < 6)) begin
        int k;
        k = wr_addr / 4;
        if (wr_unit == 2'b01)      m_reg[k][15:0]  = wr_data[15:0];
        else if (wr_unit == 2'b10) m_reg[k][31:16] = wr_data[15:0];
        else                       m_reg[k]        = wr_data;
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
      m_out = nxt;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk("R2 model pin_out", pin_out, m_out);
      chk("R4 model pin_oe", pin_oe, m_reg[4]);
      chk("R5 model readback", readback, (m_reg[4] & m_out) | (~m_reg[4] & m_s2));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [1:0] u, input logic [31:0] d, input bit en = 1'b1);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_unit = u; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic state(input logic t, input logic r);
    @(negedge clk);
    tx_active = t; rx_active = r;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset pin_out", pin_out, 32'h0);
    chk("R8 reset pin_oe", pin_oe, 32'h0);
    chk("R8 reset readback", readback, 32'h0);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);

    // R1: load patterns at stride-4 addresses
    wr(8'd0,  2'b00, 32'h1234_5678);
    wr(8'd4,  2'b00, 32'hAAAA_0001);
    wr(8'd8,  2'b00, 32'h5555_0002);
    wr(8'd12, 2'b00, 32'hF0F0_0003);
    settle();
    chk("R1 quiet pattern", pin_out, 32'h1234_5678);

    // R2: each radio condition
    state(1'b0, 1'b1); chk("R2 receive", pin_out, 32'hAAAA_0001);
    state(1'b1, 1'b0); chk("R2 transmit", pin_out, 32'h5555_0002);
    state(1'b1, 1'b1); chk("R2 full duplex", pin_out, 32'hF0F0_0003);
    // one-edge latency: change at negedge, next negedge shows it
    @(negedge clk); tx_active = 1'b0; rx_active = 1'b0;
    @(negedge clk); chk("R2 latency", pin_out, 32'h1234_5678);

    // R3: mixed static mask
    wr(8'd20, 2'b00, 32'h0000_FFFF);
    state(1'b1, 1'b0); @(negedge clk);
    chk("R3 mixed mask", pin_out, 32'h5555_5678);
    wr(8'd20, 2'b00, 32'hFFFF_FFFF);
    state(1'b1, 1'b1); @(negedge clk);
    chk("R3 all static", pin_out, 32'h1234_5678);

    // R4: direction
    wr(8'd16, 2'b00, 32'hFFFF_0000);
    chk("R4 pin_oe", pin_oe, 32'hFFFF_0000);

    // R5: readback with sync latency
    @(negedge clk); pin_in = 32'h0000_BEEF;
    @(negedge clk); chk("R5 after one edge", readback, 32'h1234_0000);
    @(negedge clk); chk("R5 after two edges", readback, 32'h1234_BEEF);

    // R6: ignored writes
    wr(8'd24, 2'b00, 32'hFFFF_FFFF);
    wr(8'd1,  2'b00, 32'hFFFF_FFFF);
    wr(8'd4,  2'b00, 32'hFFFF_FFFF, 1'b0);
    wr(8'd0,  2'b00, 32'hFFFF_FFFF, 1'b0);
    settle();
    chk("R6 quiet untouched", pin_out, 32'h1234_5678);
    wr(8'd20, 2'b00, 32'h0000_0000);
    state(1'b0, 1'b1); @(negedge clk);
    chk("R6 receive untouched", pin_out, 32'hAAAA_0001);

    // R7: half writes to full-duplex pattern
    wr(8'd12, 2'b01, 32'hDEAD_1111);
    wr(8'd12, 2'b10, 32'hBEEF_2222);
    state(1'b1, 1'b1); @(negedge clk);
    chk("R7 half writes", pin_out, 32'h2222_1111);
    wr(8'd12, 2'b11, 32'hCAFE_BABE);
    settle();
    chk("R7 full write code 11", pin_out, 32'hCAFE_BABE);

    settle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule